// File: doc/BRIEF.md
# CPU Clock Level-Change Sequencer

This block moves a processor core clock between five performance levels. Level 0 is the fastest at 1200 MHz. Levels 1 to 4 run at 1000, 800, 500 and 200 MHz. A client presents a target level on a valid/ready request port. The block compares the target with the level it currently holds. It then runs a fixed series of register writes toward the external clock hardware: two divider words, the PLL control word, a lock-time value and the core clock source select. After each write that needs one, it waits on a status handshake.

The PLL, the core source mux and the dividers sit outside the block. It sees them only through read-back words and status inputs. A change that keeps the PLL multiplier and pre-divider rewrites only the post-scaler. Any other change parks the core on the alternate clock, relocks the PLL and then returns to the main PLL. The direction of the change fixes the order of the phases.

Every status wait has a programmable cycle limit. When a limit runs out, the sequence stops, the failing step is reported and the held level stays as it was.

Top module: `clk_level_seq`

## Requirements
- R1: After reset `cur_level` is 4, `req_ready` is 1, `done` is 0 and no write strobe is active.
- R2: A request is taken only when `req_ready` is high. `req_ready` stays low from acceptance until `done`. `done` is a pulse of exactly one cycle and comes with a valid `result` and `fail_step`.
- R3: A request for the level already held finishes with `result` 0 (ok). It makes no write, and `done` rises in the cycle right after acceptance.
- R4: A target above 4 finishes with `result` 1 (bad level). It makes no write, leaves `cur_level` unchanged, and `done` rises in the cycle right after acceptance.
- R5: The PLL word places M in bits 25:16, P in bits 13:8 and S in bits 2:0. Per level, (M,P,S) is (150,3,1), (250,6,1), (200,6,1), (250,6,2) and (200,6,3) for levels 0 to 4. Every bit outside the written fields keeps its value from `pll_rd_data`.
- R6: When the old and new levels share M and P, the PLL is updated by a single write that changes only S. The source select and lock-time registers are not written.
- R7: Moving to a lower index (faster) updates the dividers first and the PLL second. Moving to a higher index does the reverse.
- R8: A relock writes these in order: source select to alternate (`mux_sel_main`=0), then waits for `mux_stat`==2. It then writes the lock time (parameter `LOCK_TIME`), then the full PLL word, then waits for `pll_locked`. Finally it writes the source select to main (`mux_sel_main`=1) and waits for `mux_stat`==1.
- R9: The first divider write holds seven 3-bit fields, field k at bits 4k+2:4k. Fields 0 to 6 are (0,3,7,3,4,1,7) for levels 0 and 1, (0,3,7,3,3,1,7) for levels 2 and 3, and (0,1,3,1,3,1,0) for level 4. All other bits are 0. The block then waits until `div0_stat` & 0x1111111 is 0.
- R10: Only after that wait is the second divider word written. Its bits 6:4 take 5, 4, 3, 3, 3 for levels 0 to 4, and bits 2:0 take 0. All other bits come from `div1_rd_data`. The block then waits until `div1_stat` & 0x11 is 0.
- R11: A wait that is still unmet after `timeout_limit`+1 cycles ends the sequence with `result` 2 (timeout) and no further write. `fail_step` names the wait: 1 alternate select, 2 PLL lock, 3 main select, 4 first divider, 5 second divider. `done` rises `timeout_limit`+2 cycles after the write that opened the wait.
- R12: `cur_level` changes only at a `done` with `result` 0, and it then takes the requested level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Level-change request present |
| req_level | input | 3 | Requested level index |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| done | output | 1 | One-cycle end-of-sequence pulse |
| result | output | 2 | 0 ok, 1 bad level, 2 timeout; valid with done |
| fail_step | output | 3 | Wait that timed out, 0 if none; valid with done |
| cur_level | output | 3 | Level currently in force |
| timeout_limit | input | TMO_W | Wait limit in cycles, minus one |
| div0_wr_en | output | 1 | First divider word write strobe |
| div0_wr_data | output | 32 | First divider word |
| div0_stat | input | 32 | First divider busy flags |
| div1_wr_en | output | 1 | Second divider word write strobe |
| div1_wr_data | output | 32 | Second divider word |
| div1_rd_data | input | 32 | Present second divider word |
| div1_stat | input | 32 | Second divider busy flags |
| pll_wr_en | output | 1 | PLL control word write strobe |
| pll_wr_data | output | 32 | PLL control word |
| pll_rd_data | input | 32 | Present PLL control word |
| pll_locked | input | 1 | PLL lock indication |
| lock_wr_en | output | 1 | Lock-time write strobe |
| lock_wr_data | output | 32 | Lock-time value |
| mux_wr_en | output | 1 | Core source select write strobe |
| mux_sel_main | output | 1 | 1 main PLL, 0 alternate clock |
| mux_stat | input | 3 | Core source mux status |

## Verification
Write strobes and their data come straight from the state register. Each is seen in the cycle that follows the edge on which the step is entered, so the bench logs strobes at falling edges and checks each data word against the read-back words of that same cycle. `done` follows the accepting edge by one cycle for same-level and bad-level requests, and the bench samples it at the first falling edge after acceptance. A timeout gives `done` exactly `timeout_limit`+2 cycles after the strobe that opened the wait, and the bench measures that gap in cycles. `cur_level` changes on the edge that ends the `done` cycle, so it is compared one falling edge later.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  localparam int          LVL_W   = 3;
  localparam logic [2:0]  SLOWEST = 3'd4;

  localparam logic [31:0] PLL_S_MASK      = 32'h0000_0007;
  localparam logic [31:0] PLL_FIELD_MASK  = 32'h03FF_3F07;
  localparam logic [31:0] DIV0_BUSY_MASK  = 32'h0111_1111;
  localparam logic [31:0] DIV1_BUSY_MASK  = 32'h0000_0011;
  localparam logic [31:0] DIV1_FIELD_MASK = 32'h0000_0077;
  localparam logic [2:0]  MUX_STAT_ALT    = 3'd2;
  localparam logic [2:0]  MUX_STAT_MAIN   = 3'd1;

  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_BAD_LEVEL = 2'd1,
    RES_TIMEOUT   = 2'd2
  } result_e;

  typedef enum logic [2:0] {
    STEP_NONE     = 3'd0,
    STEP_ALT_SEL  = 3'd1,
    STEP_PLL_LOCK = 3'd2,
    STEP_MAIN_SEL = 3'd3,
    STEP_DIV0     = 3'd4,
    STEP_DIV1     = 3'd5
  } step_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DIV0_WR, ST_DIV0_WAIT, ST_DIV1_WR, ST_DIV1_WAIT,
    ST_S_WR, ST_ALT_SEL, ST_ALT_WAIT, ST_LOCK_WR, ST_PLL_WR,
    ST_LOCK_WAIT, ST_MAIN_SEL, ST_MAIN_WAIT, ST_FIN
  } state_e;

  typedef struct packed {
    logic [9:0] m;
    logic [5:0] p;
    logic [2:0] s;
  } pms_t;

  // Multiplier, pre-divider and post-scaler per level (out-of-range -> slowest)
  function automatic pms_t level_pms(logic [2:0] lvl);
    pms_t v;
    case (lvl)
      3'd0:    v = '{m: 10'd150, p: 6'd3, s: 3'd1};
      3'd1:    v = '{m: 10'd250, p: 6'd6, s: 3'd1};
      3'd2:    v = '{m: 10'd200, p: 6'd6, s: 3'd1};
      3'd3:    v = '{m: 10'd250, p: 6'd6, s: 3'd2};
      default: v = '{m: 10'd200, p: 6'd6, s: 3'd3};
    endcase
    return v;
  endfunction

  function automatic logic [31:0] pack_pms(pms_t v);
    return {6'd0, v.m, 2'd0, v.p, 5'd0, v.s};
  endfunction

  // True when a full relock is required between two levels
  function automatic logic needs_relock(logic [2:0] from_lvl, logic [2:0] to_lvl);
    pms_t a;
    pms_t b;
    a = level_pms(from_lvl);
    b = level_pms(to_lvl);
    return (a.m != b.m) || (a.p != b.p);
  endfunction

  // Seven 3-bit divider fields, field k placed at bits 4k+2:4k
  function automatic logic [31:0] div0_word(logic [2:0] lvl);
    logic [6:0][2:0] f;
    logic [31:0]     w;
    if (lvl == 3'd4)      f = {3'd0, 3'd1, 3'd3, 3'd1, 3'd3, 3'd1, 3'd0};
    else if (lvl < 3'd2)  f = {3'd7, 3'd1, 3'd4, 3'd3, 3'd7, 3'd3, 3'd0};
    else                  f = {3'd7, 3'd1, 3'd3, 3'd3, 3'd7, 3'd3, 3'd0};
    w = '0;
    for (int k = 0; k < 7; k++) w[4*k +: 3] = f[k];
    return w;
  endfunction

  function automatic logic [31:0] div1_fields(logic [2:0] lvl);
    logic [2:0] hi;
    case (lvl)
      3'd0:    hi = 3'd5;
      3'd1:    hi = 3'd4;
      default: hi = 3'd3;
    endcase
    return {25'd0, hi, 1'b0, 3'd0};
  endfunction

  function automatic logic is_wait(state_e st);
    return (st == ST_DIV0_WAIT) || (st == ST_DIV1_WAIT) || (st == ST_ALT_WAIT) ||
           (st == ST_LOCK_WAIT) || (st == ST_MAIN_WAIT);
  endfunction

  function automatic step_e step_of(state_e st);
    case (st)
      ST_ALT_WAIT:  return STEP_ALT_SEL;
      ST_LOCK_WAIT: return STEP_PLL_LOCK;
      ST_MAIN_WAIT: return STEP_MAIN_SEL;
      ST_DIV0_WAIT: return STEP_DIV0;
      ST_DIV1_WAIT: return STEP_DIV1;
      default:      return STEP_NONE;
    endcase
  endfunction

  function automatic logic wait_met(state_e st, logic [2:0] mux, logic lk,
                                    logic [31:0] d0, logic [31:0] d1);
    case (st)
      ST_ALT_WAIT:  return mux == MUX_STAT_ALT;
      ST_LOCK_WAIT: return lk;
      ST_MAIN_WAIT: return mux == MUX_STAT_MAIN;
      ST_DIV0_WAIT: return (d0 & DIV0_BUSY_MASK) == 32'd0;
      ST_DIV1_WAIT: return (d1 & DIV1_BUSY_MASK) == 32'd0;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/clkseq_wait_timer.sv
module clkseq_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             waiting,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!waiting)     cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end

  assign expired = waiting && (cnt == limit);
endmodule

// File: rtl/clkseq_ctrl.sv
module clkseq_ctrl
  import clkseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             wait_ok,
  input  logic             wait_expired,
  output state_e           state,
  output logic [LVL_W-1:0] tgt,
  output logic [LVL_W-1:0] cur_level,
  output result_e          result,
  output step_e            fail_step
);
  state_e nxt;
  logic   faster;
  logic   relock;
  logic   accept;
  logic   abort;
  logic   pll_start_relock;

  assign accept = (state == ST_IDLE) && req_valid;
  assign abort  = is_wait(state) && !wait_ok && wait_expired;
  assign pll_start_relock = relock;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_level > SLOWEST || req_level == cur_level) nxt = ST_FIN;
          else if (req_level < cur_level)                    nxt = ST_DIV0_WR;
          else if (needs_relock(cur_level, req_level))       nxt = ST_ALT_SEL;
          else                                               nxt = ST_S_WR;
        end
      end
      ST_DIV0_WR:   nxt = ST_DIV0_WAIT;
      ST_DIV0_WAIT: if (wait_ok) nxt = ST_DIV1_WR; else if (wait_expired) nxt = ST_FIN;
      ST_DIV1_WR:   nxt = ST_DIV1_WAIT;
      ST_DIV1_WAIT: begin
        if (wait_ok) begin
          if (!faster)               nxt = ST_FIN;
          else if (pll_start_relock) nxt = ST_ALT_SEL;
          else                       nxt = ST_S_WR;
        end else if (wait_expired) nxt = ST_FIN;
      end
      ST_S_WR:      nxt = faster ? ST_FIN : ST_DIV0_WR;
      ST_ALT_SEL:   nxt = ST_ALT_WAIT;
      ST_ALT_WAIT:  if (wait_ok) nxt = ST_LOCK_WR; else if (wait_expired) nxt = ST_FIN;
      ST_LOCK_WR:   nxt = ST_PLL_WR;
      ST_PLL_WR:    nxt = ST_LOCK_WAIT;
      ST_LOCK_WAIT: if (wait_ok) nxt = ST_MAIN_SEL; else if (wait_expired) nxt = ST_FIN;
      ST_MAIN_SEL:  nxt = ST_MAIN_WAIT;
      ST_MAIN_WAIT: begin
        if (wait_ok)               nxt = faster ? ST_FIN : ST_DIV0_WR;
        else if (wait_expired)     nxt = ST_FIN;
      end
      ST_FIN:       nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tgt       <= SLOWEST;
      cur_level <= SLOWEST;
      faster    <= 1'b0;
      relock    <= 1'b0;
      result    <= RES_OK;
      fail_step <= STEP_NONE;
    end else begin
      state <= nxt;
      if (accept) begin
        tgt       <= req_level;
        faster    <= req_level < cur_level;
        relock    <= needs_relock(cur_level, req_level);
        result    <= (req_level > SLOWEST) ? RES_BAD_LEVEL : RES_OK;
        fail_step <= STEP_NONE;
      end
      if (abort) begin
        result    <= RES_TIMEOUT;
        fail_step <= step_of(state);
      end
      if (state == ST_FIN && result == RES_OK) cur_level <= tgt;
    end
  end
endmodule

// File: rtl/clkseq_writer.sv
module clkseq_writer
  import clkseq_pkg::*;
#(
  parameter logic [31:0] LOCK_TIME = 32'h0000_2000
) (
  input  state_e           state,
  input  logic [LVL_W-1:0] tgt,
  input  logic [31:0]      pll_rd_data,
  input  logic [31:0]      div1_rd_data,
  output logic             div0_wr_en,
  output logic [31:0]      div0_wr_data,
  output logic             div1_wr_en,
  output logic [31:0]      div1_wr_data,
  output logic             pll_wr_en,
  output logic [31:0]      pll_wr_data,
  output logic             lock_wr_en,
  output logic [31:0]      lock_wr_data,
  output logic             mux_wr_en,
  output logic             mux_sel_main
);
  logic [31:0] tgt_pll;
  assign tgt_pll = pack_pms(level_pms(tgt));

  assign div0_wr_en   = (state == ST_DIV0_WR);
  assign div0_wr_data = div0_word(tgt);

  assign div1_wr_en   = (state == ST_DIV1_WR);
  assign div1_wr_data = (div1_rd_data & ~DIV1_FIELD_MASK) | div1_fields(tgt);

  assign pll_wr_en    = (state == ST_S_WR) || (state == ST_PLL_WR);
  always_comb begin
    if (state == ST_S_WR) pll_wr_data = (pll_rd_data & ~PLL_S_MASK) | (tgt_pll & PLL_S_MASK);
    else                  pll_wr_data = (pll_rd_data & ~PLL_FIELD_MASK) | tgt_pll;
  end

  assign lock_wr_en   = (state == ST_LOCK_WR);
  assign lock_wr_data = LOCK_TIME;

  assign mux_wr_en    = (state == ST_ALT_SEL) || (state == ST_MAIN_SEL);
  assign mux_sel_main = (state == ST_MAIN_SEL);
endmodule

// File: rtl/clk_level_seq.sv
module clk_level_seq
  import clkseq_pkg::*;
#(
  parameter int          TMO_W     = 16,
  parameter logic [31:0] LOCK_TIME = 32'h0000_2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_level,
  output logic             req_ready,
  output logic             done,
  output logic [1:0]       result,
  output logic [2:0]       fail_step,
  output logic [2:0]       cur_level,
  input  logic [TMO_W-1:0] timeout_limit,
  output logic             div0_wr_en,
  output logic [31:0]      div0_wr_data,
  input  logic [31:0]      div0_stat,
  output logic             div1_wr_en,
  output logic [31:0]      div1_wr_data,
  input  logic [31:0]      div1_rd_data,
  input  logic [31:0]      div1_stat,
  output logic             pll_wr_en,
  output logic [31:0]      pll_wr_data,
  input  logic [31:0]      pll_rd_data,
  input  logic             pll_locked,
  output logic             lock_wr_en,
  output logic [31:0]      lock_wr_data,
  output logic             mux_wr_en,
  output logic             mux_sel_main,
  input  logic [2:0]       mux_stat
);
  state_e           state;
  logic [LVL_W-1:0] tgt;
  result_e          res_q;
  step_e            step_q;
  logic             waiting;
  logic             wait_ok;
  logic             wait_expired;

  assign waiting = is_wait(state);
  assign wait_ok = wait_met(state, mux_stat, pll_locked, div0_stat, div1_stat);

  clkseq_wait_timer #(.TMO_W(TMO_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (waiting),
    .limit   (timeout_limit),
    .expired (wait_expired)
  );

  clkseq_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_level    (req_level),
    .wait_ok      (wait_ok),
    .wait_expired (wait_expired),
    .state        (state),
    .tgt          (tgt),
    .cur_level    (cur_level),
    .result       (res_q),
    .fail_step    (step_q)
  );

  clkseq_writer #(.LOCK_TIME(LOCK_TIME)) i_writer (
    .state        (state),
    .tgt          (tgt),
    .pll_rd_data  (pll_rd_data),
    .div1_rd_data (div1_rd_data),
    .div0_wr_en   (div0_wr_en),
    .div0_wr_data (div0_wr_data),
    .div1_wr_en   (div1_wr_en),
    .div1_wr_data (div1_wr_data),
    .pll_wr_en    (pll_wr_en),
    .pll_wr_data  (pll_wr_data),
    .lock_wr_en   (lock_wr_en),
    .lock_wr_data (lock_wr_data),
    .mux_wr_en    (mux_wr_en),
    .mux_sel_main (mux_sel_main)
  );

  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_FIN);
  assign result    = res_q;
  assign fail_step = step_q;
endmodule

// File: rtl/clk_level_seq_chk.sv
module clk_level_seq_chk
  import clkseq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic [1:0]  result,
  input logic [2:0]  cur_level,
  input logic        div0_wr_en,
  input logic [31:0] div0_stat,
  input logic        div1_wr_en,
  input logic [31:0] div1_wr_data,
  input logic [31:0] div1_rd_data,
  input logic        pll_wr_en,
  input logic [31:0] pll_wr_data,
  input logic [31:0] pll_rd_data,
  input logic        pll_locked,
  input logic        lock_wr_en,
  input logic        mux_wr_en,
  input logic        mux_sel_main
);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  a_r2_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div0_wr_en, div1_wr_en, pll_wr_en, lock_wr_en, mux_wr_en}));

  a_r12_level_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level) |-> ($past(done) && $past(result) == 2'd0));

  a_r12_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level <= 3'd4);

  a_r5_pll_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    pll_wr_en |-> ((pll_wr_data ^ pll_rd_data) & ~PLL_FIELD_MASK) == 32'd0);

  a_r8_lock_then_pll: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr_en |=> pll_wr_en);

  a_r8_main_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_wr_en && mux_sel_main) |-> $past(pll_locked));

  a_r10_div1_after_div0: assert property (@(posedge clk) disable iff (!rst_n)
    div1_wr_en |-> $past((div0_stat & DIV0_BUSY_MASK) == 32'd0));

  a_r10_div1_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    div1_wr_en |-> ((div1_wr_data ^ div1_rd_data) & ~DIV1_FIELD_MASK) == 32'd0);
endmodule

bind clk_level_seq clk_level_seq_chk i_chk (.*);

// File: tb/test_clk_level_seq.sv
module test_clk_level_seq;
  localparam int          MDLY = 3;
  localparam logic [31:0] LT   = 32'h0000_2000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = 3'd0;
  logic        req_ready, done;
  logic [1:0]  result;
  logic [2:0]  fail_step, cur_level;
  logic [15:0] timeout_limit = 16'd100;
  logic        div0_wr_en, div1_wr_en, pll_wr_en, lock_wr_en, mux_wr_en, mux_sel_main;
  logic [31:0] div0_wr_data, div1_wr_data, pll_wr_data, lock_wr_data;
  logic [31:0] div0_stat = 32'd0, div1_stat = 32'd0, div1_word = 32'h0000_0F00;
  logic [31:0] pll_word = 32'h8000_00A0 | ((32'd200 << 16) | (32'd6 << 8) | 32'd3);
  logic        pll_locked = 1'b1;
  logic [2:0]  mux_stat = 3'd1, mux_tgt = 3'd1;
  int          mux_cnt = 0, lk_cnt = 0, d0_cnt = 0, d1_cnt = 0;
  bit          stuck_mux = 0, stuck_lock = 0, stuck_div1 = 0;

  clk_level_seq i_clk_level_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .req_ready(req_ready), .done(done), .result(result), .fail_step(fail_step),
    .cur_level(cur_level), .timeout_limit(timeout_limit),
    .div0_wr_en(div0_wr_en), .div0_wr_data(div0_wr_data), .div0_stat(div0_stat),
    .div1_wr_en(div1_wr_en), .div1_wr_data(div1_wr_data), .div1_rd_data(div1_word),
    .div1_stat(div1_stat), .pll_wr_en(pll_wr_en), .pll_wr_data(pll_wr_data),
    .pll_rd_data(pll_word), .pll_locked(pll_locked), .lock_wr_en(lock_wr_en),
    .lock_wr_data(lock_wr_data), .mux_wr_en(mux_wr_en), .mux_sel_main(mux_sel_main),
    .mux_stat(mux_stat)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side level tables
  function automatic logic [31:0] b_pll(int l);
    int m, p, s;
    case (l)
      0: begin m = 150; p = 3; s = 1; end
      1: begin m = 250; p = 6; s = 1; end
      2: begin m = 200; p = 6; s = 1; end
      3: begin m = 250; p = 6; s = 2; end
      default: begin m = 200; p = 6; s = 3; end
    endcase
    return 32'(m) * 32'h10000 + 32'(p) * 32'h100 + 32'(s);
  endfunction

  function automatic logic [31:0] b_div0(int l);
    int f[7];
    logic [31:0] w;
    f[0] = 0; f[5] = 1;
    f[1] = (l == 4) ? 1 : 3;
    f[2] = (l == 4) ? 3 : 7;
    f[3] = (l == 4) ? 1 : 3;
    f[4] = (l < 2) ? 4 : 3;
    f[6] = (l == 4) ? 0 : 7;
    w = 0;
    for (int k = 0; k < 7; k++) w = w + (32'(f[k]) << (4 * k));
    return w;
  endfunction

  function automatic logic [31:0] b_div1(int l);
    return (l == 0) ? 32'h50 : (l == 1) ? 32'h40 : 32'h30;
  endfunction

  function automatic bit b_relock(int a, int b);
    return (b_pll(a) >> 8) != (b_pll(b) >> 8);
  endfunction

  // External clock hardware model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mux_wr_en) begin
      mux_stat <= 3'd0; mux_tgt <= mux_sel_main ? 3'd1 : 3'd2; mux_cnt <= MDLY;
    end else if (mux_cnt > 0) mux_cnt <= mux_cnt - 1;
    else if (!stuck_mux && mux_stat == 3'd0) mux_stat <= mux_tgt;

    if (pll_wr_en) begin
      pll_word <= pll_wr_data; pll_locked <= 1'b0; lk_cnt <= MDLY;
    end else if (lk_cnt > 0) lk_cnt <= lk_cnt - 1;
    else if (!stuck_lock) pll_locked <= 1'b1;

    if (div0_wr_en) begin
      div0_stat <= 32'h0111_1111; d0_cnt <= MDLY;
    end else if (d0_cnt > 0) d0_cnt <= d0_cnt - 1;
    else div0_stat <= 32'd0;

    if (div1_wr_en) begin
      div1_word <= div1_wr_data; div1_stat <= 32'h11; d1_cnt <= MDLY;
    end else if (d1_cnt > 0) d1_cnt <= d1_cnt - 1;
    else if (!stuck_div1) div1_stat <= 32'd0;
  end

  // Write log: 1 div0, 2 div1, 3 pll, 4 lock time, 5 select alternate, 6 select main
  int log_q[$];
  int exp_tgt = 4, model_level = 4, alt_cyc = 0;
  bit exp_relock = 0;

  always @(negedge clk) if (rst_n) begin
    if (div0_wr_en) begin
      log_q.push_back(1);
      chk(div0_wr_data == b_div0(exp_tgt), "R9 div0 word", div0_wr_data, b_div0(exp_tgt));
    end
    if (div1_wr_en) begin
      log_q.push_back(2);
      chk(div1_wr_data == ((div1_word & ~32'h77) | b_div1(exp_tgt)), "R10 div1 word",
          div1_wr_data, (div1_word & ~32'h77) | b_div1(exp_tgt));
    end
    if (pll_wr_en) begin
      logic [31:0] e;
      log_q.push_back(3);
      if (exp_relock) e = (pll_word & ~32'h03FF_3F07) | b_pll(exp_tgt);
      else            e = (pll_word & ~32'h7) | (b_pll(exp_tgt) & 32'h7);
      chk(pll_wr_data == e, exp_relock ? "R5 pll word" : "R6 pll s-only word", pll_wr_data, e);
    end
    if (lock_wr_en) begin
      log_q.push_back(4);
      chk(lock_wr_data == LT, "R8 lock time", lock_wr_data, LT);
    end
    if (mux_wr_en) begin
      log_q.push_back(mux_sel_main ? 6 : 5);
      if (!mux_sel_main) alt_cyc = cyc;
    end
  end

  int exp_seq[8];
  int exp_n;

  task automatic build_seq(int o, int n);
    int pll_part[4];
    int pn;
    exp_n = 0;
    if (b_relock(o, n)) begin
      pll_part = '{5, 4, 3, 6}; pn = 4;
    end else begin
      pll_part = '{3, 0, 0, 0}; pn = 1;
    end
    if (n < o) begin
      exp_seq[0] = 1; exp_seq[1] = 2; exp_n = 2;
      for (int i = 0; i < pn; i++) begin exp_seq[exp_n] = pll_part[i]; exp_n++; end
    end else begin
      for (int i = 0; i < pn; i++) begin exp_seq[exp_n] = pll_part[i]; exp_n++; end
      exp_seq[exp_n] = 1; exp_seq[exp_n + 1] = 2; exp_n += 2;
    end
  endtask

  int r_res, r_step, r_lat, r_done_cyc;

  task automatic run_req(int tgt);
    bit ready_low = 1;
    log_q.delete();
    exp_tgt = tgt;
    exp_relock = (tgt <= 4) ? b_relock(model_level, tgt) : 0;
    @(negedge clk);
    req_valid = 1'b1; req_level = 3'(tgt);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0;
    while (!done && r_lat < 3000) begin
      if (req_ready) ready_low = 0;
      @(negedge clk);
      r_lat++;
    end
    chk(ready_low, "R2 ready low while busy", 32'(ready_low), 1);
    chk(done == 1'b1, "R2 done seen", 32'(done), 1);
    r_res = result; r_step = fail_step; r_done_cyc = cyc;
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", 32'(done), 0);
  endtask

  task automatic check_log(string req);
    chk(log_q.size() == exp_n, req, log_q.size(), exp_n);
    for (int i = 0; i < exp_n && i < log_q.size(); i++)
      chk(log_q[i] == exp_seq[i], req, log_q[i], exp_seq[i]);
  endtask

  // Stimulus table: {target level, expected result}
  localparam int VEC [12][2] = '{
    '{2, 0}, '{0, 0}, '{0, 0}, '{1, 0}, '{3, 0}, '{4, 0},
    '{7, 1}, '{1, 0}, '{3, 0}, '{2, 0}, '{4, 0}, '{4, 0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_level == 3'd4, "R1 reset level", cur_level, 4);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk({div0_wr_en, div1_wr_en, pll_wr_en, lock_wr_en, mux_wr_en} == 5'd0,
        "R1 reset strobes", {div0_wr_en, div1_wr_en, pll_wr_en, lock_wr_en, mux_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      int t, old;
      t = VEC[v][0]; old = model_level;
      run_req(t);
      chk(r_res == VEC[v][1], "R2 result", r_res, VEC[v][1]);
      if (t > 4) begin
        chk(r_lat == 0, "R4 bad level latency", r_lat, 0);
        chk(log_q.size() == 0, "R4 bad level no writes", log_q.size(), 0);
      end else if (t == old) begin
        chk(r_lat == 0, "R3 same level latency", r_lat, 0);
        chk(log_q.size() == 0, "R3 same level no writes", log_q.size(), 0);
      end else begin
        build_seq(old, t);
        check_log(b_relock(old, t) ? "R8 relock order" : "R6 s-only order");
        check_log("R7 phase order");
        model_level = t;
      end
      chk(cur_level == 3'(model_level), "R12 level after done", cur_level, model_level);
    end

    // R11 timeouts, limit 5
    timeout_limit = 16'd5;
    stuck_mux = 1;
    run_req(0);
    chk(r_res == 2, "R11 timeout result", r_res, 2);
    chk(r_step == 1, "R11 step alt select", r_step, 1);
    chk(r_done_cyc - alt_cyc == 7, "R11 timeout latency", r_done_cyc - alt_cyc, 7);
    exp_seq = '{1, 2, 5, 0, 0, 0, 0, 0}; exp_n = 3;
    check_log("R11 writes stop");
    chk(cur_level == 3'd4, "R12 level kept on timeout", cur_level, 4);
    stuck_mux = 0;

    stuck_lock = 1;
    run_req(1);
    chk(r_res == 2, "R11 timeout result", r_res, 2);
    chk(r_step == 2, "R11 step pll lock", r_step, 2);
    exp_seq = '{1, 2, 5, 4, 3, 0, 0, 0}; exp_n = 5;
    check_log("R11 writes stop");
    chk(cur_level == 3'd4, "R12 level kept on timeout", cur_level, 4);
    stuck_lock = 0;

    stuck_div1 = 1;
    run_req(2);
    chk(r_res == 2, "R11 timeout result", r_res, 2);
    chk(r_step == 5, "R11 step div1", r_step, 5);
    exp_seq = '{1, 2, 0, 0, 0, 0, 0, 0}; exp_n = 2;
    check_log("R11 writes stop");
    chk(cur_level == 3'd4, "R12 level kept on timeout", cur_level, 4);
    stuck_div1 = 0;

    // Recovery after faults
    timeout_limit = 16'd100;
    repeat (10) @(negedge clk);
    run_req(0);
    chk(r_res == 0, "R8 recovery result", r_res, 0);
    build_seq(4, 0);
    check_log("R8 recovery order");
    model_level = 0;
    chk(cur_level == 3'd0, "R12 level after recovery", cur_level, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule